// File: doc/BRIEF.md
# Sequential-Prefetch ROM Port Controller

This controller sits between a processor's tightly-coupled instruction port and a synchronous ROM. The ROM captures its address and chip select on a clock edge and presents the word one cycle later. The controller drives that address from its own registers, so the late-arriving processor address never sits on the ROM's input path. In normal running it guesses the next address with a local incrementer. A sequential fetch stream therefore completes one word per cycle with no wait state.

When the guess cannot be trusted, the controller stalls the processor for one cycle. This happens on a nonsequential fetch, on the first fetch after reset, after idle cycles, and on any sequential fetch whose address differs from the prefetch address. During that cycle the ROM is re-addressed from a registered copy of the processor address. The processor holds its address and controls steady while `stall` is high. A word is presented on `rd_data` in every cycle in which `rd_valid` is high. The processor side has no other back-pressure: `stall` is the only flow-control signal, and the controller never buffers more than the one word in flight.

The ROM chip select follows the processor chip select one cycle late. The incrementer advances only in cycles in which the ROM is read. Because of this, the ROM address can trail, equal or run ahead of the processor address. The hit comparison sorts out all three cases.

Top module: `seq_rom_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stall`, `rd_valid` and `rom_cs` are low.
- R2: `rom_cs` in any cycle equals `req_cs` of the previous cycle.
- R3: In a cycle where `rom_cs` is high and no stall follows, the ROM address of the next cycle is the current ROM address plus one, wrapping from 18'h3FFFF to 0.
- R4: In a cycle where `rom_cs` is low and no stall follows, the ROM address of the next cycle equals the current one, so an idle cycle reads nothing and does not advance the incrementer.
- R5: A request with `req_cs`=1 and `req_seq`=0, made while `stall` is low, raises `stall` in the next cycle and drives that request's address on `rom_addr` in that cycle. This holds even when the address equals the prefetched one.
- R6: A sequential request (`req_seq`=1) that arrives while `rom_cs` is high and `rom_addr` equals `req_addr` completes with no wait. In the next cycle `stall` is low, `rd_valid` is high and `rd_data` is the ROM word at that address.
- R7: A sequential request that does not meet the R6 condition gets exactly one wait cycle and then returns the correct word. Such requests include those after idle cycles (ROM ahead) and address jumps.
- R8: The first request after reset takes one wait cycle even when `req_seq`=1.
- R9: If the processor holds its request steady during a stall cycle, the next cycle has `stall` low, `rd_valid` high and the correct word. No request waits more than one cycle.
- R10: `stall` and `rd_valid` are never high in the same cycle. Both are low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | 18 | Processor word address |
| req_cs | input | 1 | Processor fetch request |
| req_seq | input | 1 | Request is sequential to the previous one |
| rd_data | output | 32 | Word returned to the processor |
| rd_valid | output | 1 | `rd_data` carries the word of the last accepted request |
| stall | output | 1 | Wait state; the processor holds its request |
| rom_addr | output | 18 | Address to the synchronous ROM |
| rom_cs | output | 1 | Read enable to the ROM |
| rom_rdata | input | 32 | ROM read word, one cycle after the address |

## Verification
The hardest case is the ROM running ahead of the processor. It needs an access, then an idle cycle in which the speculative read still advances the incrementer, then a sequential request for the word right after the last access. The directed idle test builds exactly that sequence and expects one wait and the correct word. A random mix then weights idle cycles heavily. For every request, the bench predicts zero or one wait from the previous step alone.

// File: rtl/seq_rom_pkg.sv
package seq_rom_pkg;
  localparam int ROM_AW = 18;
  localparam int ROM_DW = 32;

  typedef enum logic [1:0] {
    SRC_INCR = 2'b01,
    SRC_REQ  = 2'b10
  } addr_src_e;
endpackage

// File: rtl/seq_rom_addr_gen.sv
module seq_rom_addr_gen #(
  parameter int AW = seq_rom_pkg::ROM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] req_addr,
  input  logic          reload,
  input  logic          advance,
  output logic [AW-1:0] rom_addr
);
  import seq_rom_pkg::*;

  logic [AW-1:0] req_addr_q;
  logic [AW-1:0] incr_q;
  addr_src_e     src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_addr_q <= '0;
      incr_q     <= '0;
      src_q      <= SRC_INCR;
    end else begin
      req_addr_q <= req_addr;
      src_q      <= reload ? SRC_REQ : SRC_INCR;
      if (advance) incr_q <= rom_addr + AW'(1);
      else         incr_q <= rom_addr;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_REQ: rom_addr = req_addr_q;
      default: rom_addr = incr_q;
    endcase
  end
endmodule

// File: rtl/seq_rom_hit_ctrl.sv
module seq_rom_hit_ctrl #(
  parameter int AW = seq_rom_pkg::ROM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] req_addr,
  input  logic          req_cs,
  input  logic          req_seq,
  input  logic [AW-1:0] rom_addr,
  output logic          rom_cs,
  output logic          miss,
  output logic          stall,
  output logic          rd_valid
);
  logic cs_q, stall_q, valid_q, started_q;
  logic addr_eq, seq_trust, hit;

  assign addr_eq   = (rom_addr == req_addr);
  assign seq_trust = stall_q | (req_seq & started_q);
  assign hit       = req_cs & cs_q & addr_eq & seq_trust;
  assign miss      = req_cs & ~hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= 1'b0;
      stall_q   <= 1'b0;
      valid_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cs_q    <= req_cs;
      stall_q <= miss;
      valid_q <= hit;
      if (req_cs) started_q <= 1'b1;
    end
  end

  assign rom_cs   = cs_q;
  assign stall    = stall_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/seq_rom_port.sv
module seq_rom_port #(
  parameter int AW = seq_rom_pkg::ROM_AW,
  parameter int DW = seq_rom_pkg::ROM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] req_addr,
  input  logic          req_cs,
  input  logic          req_seq,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          stall,
  output logic [AW-1:0] rom_addr,
  output logic          rom_cs,
  input  logic [DW-1:0] rom_rdata
);
  logic miss;

  seq_rom_hit_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_addr (req_addr),
    .req_cs   (req_cs),
    .req_seq  (req_seq),
    .rom_addr (rom_addr),
    .rom_cs   (rom_cs),
    .miss     (miss),
    .stall    (stall),
    .rd_valid (rd_valid)
  );

  seq_rom_addr_gen #(.AW(AW)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_addr (req_addr),
    .reload   (miss),
    .advance  (rom_cs),
    .rom_addr (rom_addr)
  );

  assign rd_data = rom_rdata;
endmodule

// File: rtl/seq_rom_port_chk.sv
module seq_rom_port_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] req_addr,
  input logic          req_cs,
  input logic          req_seq,
  input logic          rd_valid,
  input logic          stall,
  input logic [AW-1:0] rom_addr,
  input logic          rom_cs
);
  p_cs_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_cs |=> rom_cs);
  p_cs_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_cs |=> !rom_cs);
  p_incr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rom_cs) && !stall) |-> rom_addr == AW'($past(rom_addr) + AW'(1)));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rom_cs) && !stall) |-> rom_addr == $past(rom_addr));
  p_nonseq_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cs && !req_seq && !stall) |=> (stall && rom_addr == $past(req_addr)));
  p_seq_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cs && req_seq && rom_cs && rom_addr == req_addr && !stall) |=> (rd_valid && !stall));
  p_retry_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && req_cs && $stable(req_addr)) |=> (!stall && rd_valid));
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && rd_valid));
endmodule

bind seq_rom_port seq_rom_port_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_addr (req_addr),
  .req_cs   (req_cs),
  .req_seq  (req_seq),
  .rd_valid (rd_valid),
  .stall    (stall),
  .rom_addr (rom_addr),
  .rom_cs   (rom_cs)
);

// File: tb/seq_rom_port_tb.sv
module seq_rom_port_tb;
  localparam int AW = 18;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_cs = 1'b0;
  logic          req_seq = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, stall, rom_cs;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit had_access = 1'b0;
  bit prev_access = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always #2 clk = ~clk;

  seq_rom_port #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_cs(req_cs),
    .req_seq(req_seq), .rd_data(rd_data), .rd_valid(rd_valid), .stall(stall),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata)
  );

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    return {a[13:0], a ^ 18'h2A5C3};
  endfunction

  always_ff @(posedge clk) if (rom_cs) rom_rdata <= rom_word(rom_addr);

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; expected waits follow from the requirements.
  task automatic access(input logic [AW-1:0] a, input bit seq, input string req);
    int waits = 0;
    int exp_w;
    exp_w = (seq && had_access && prev_access && a == AW'(prev_addr + 1)) ? 0 : 1;
    req_cs = 1'b1; req_addr = a; req_seq = seq;
    @(posedge clk); #1;
    while (stall && waits < 4) begin
      check({req, " no valid during stall"}, DW'(rd_valid), '0);
      waits++;
      @(posedge clk); #1;
    end
    check({req, " wait count"}, DW'(waits), DW'(exp_w));
    check({req, " valid"}, DW'(rd_valid), 32'd1);
    check({req, " data"}, rd_data, rom_word(a));
    had_access = 1'b1; prev_access = 1'b1; prev_addr = a;
  endtask

  task automatic idle();
    req_cs = 1'b0; req_seq = 1'b0;
    @(posedge clk); #1;
    check("R10 idle quiet", DW'({stall, rd_valid}), '0);
    check("R2 rom_cs after idle", DW'(rom_cs), '0);
    prev_access = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset outputs", DW'({stall, rd_valid, rom_cs}), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle out of reset", DW'({stall, rd_valid, rom_cs}), '0);
  endtask

  task automatic t_first_seq();
    access(18'h00100, 1'b1, "R8 first access seq");
  endtask

  task automatic t_stream();
    access(18'h00200, 1'b0, "R5 nonseq");
    access(18'h00201, 1'b1, "R6 seq hit");
    access(18'h00202, 1'b1, "R6 R3 seq hit");
    access(18'h00203, 1'b1, "R6 R3 seq hit");
  endtask

  task automatic t_idle_lead();
    logic [AW-1:0] held;
    idle();
    held = rom_addr;
    idle();
    check("R4 rom_addr held over idle", DW'(rom_addr), DW'(held));
    prev_access = 1'b0;
    access(18'h00204, 1'b1, "R7 seq after idle (ROM ahead)");
    access(18'h00205, 1'b1, "R6 back in step");
  endtask

  task automatic t_jump();
    access(18'h00300, 1'b0, "R5 nonseq");
    access(18'h00301, 1'b1, "R6 seq hit");
    access(18'h00310, 1'b1, "R7 seq jump");
    access(18'h00311, 1'b1, "R6 after jump");
  endtask

  task automatic t_wrap();
    access(18'h3FFFF, 1'b0, "R5 nonseq top");
    access(18'h00000, 1'b1, "R3 wrap");
  endtask

  task automatic t_nonseq_match();
    access(18'h00400, 1'b0, "R5 nonseq");
    access(18'h00401, 1'b1, "R6 seq hit");
    access(18'h00402, 1'b0, "R5 nonseq equal to prefetch");
    access(18'h00403, 1'b1, "R9 R6 after forced wait");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 3) idle();
      else if (r < 8) access(AW'(prev_addr + 1), 1'b1, "R9 random seq");
      else access(AW'($urandom), 1'b0, "R9 random nonseq");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_first_seq();
    t_stream();
    t_idle_lead();
    t_jump();
    t_wrap();
    t_nonseq_match();
    t_random();
    idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule